// File: doc/BRIEF.md
# Key Snapshot Queue with Register Access

This block sits behind a keyboard matrix scanner. Each time the scanner finishes a pass, it offers one snapshot of up to eight pressed keys. The block stores accepted snapshots in a small first-in first-out queue. Software reads them over a simple 32-bit register bus, and the block raises a level interrupt once the queue holds as many snapshots as a programmed threshold.

Each snapshot is 64 bits wide and holds eight byte slots. In each slot, bit 7 flags the slot as used, bits 6:3 carry the row and bits 2:0 carry the column. Software reads the oldest snapshot as two 32-bit words. The low word is read first, and reading the high word then retires the snapshot.

The register file also holds settings for the scanner. These are the scan enable, the debounce count, an initial delay, a repeat delay and one wake mask per row. They are passed out unchanged on dedicated output pins.

Top module: `keyscan_fifo_regs`

## Requirements
- R1: After reset the queue is empty and the interrupt output is low. Every register reads zero, including CTRL, STATUS, the delays and all wake masks, and every output holds zero.
- R2: CTRL at offset 0x00 holds four fields. Bit 0 is the scan enable, bit 3 is the interrupt enable, bits 13:4 are the debounce count and bits 17:14 are the threshold. The other bits are not stored and read zero. The scan enable drives `scan_en_o` and the debounce count drives `debounce_o`.
- R3: A snapshot offered on `snap_valid_i` is stored only while CTRL bit 0 is set. STATUS at offset 0x04 reports the number of stored snapshots in bits 7:4.
- R4: The word at 0x30 holds slots 0 to 3 of the oldest snapshot, with slot 0 in the least significant byte. The word at 0x34 holds slots 4 to 7. A slot whose bit 7 is clear reads as 0x00.
- R5: Reading 0x34 retires the oldest snapshot only when the previous entry-word read was 0x30. A read of 0x34 without a preceding read of 0x30 retires nothing. Snapshots come out in the order they were accepted.
- R6: When the queue holds DEPTH snapshots, a newly offered snapshot is dropped and the stored ones are unchanged.
- R7: While the queue is empty, both entry words read zero, and reads of them leave the count at zero.
- R8: `irq_o` is high exactly while the interrupt enable is set, the threshold is non-zero and the stored count is at or above the threshold.
- R9: STATUS bit 2 sets one cycle after the count rises from below the threshold to at or above it. Writing a 1 to that bit clears it, and writing a 0 leaves it unchanged.
- R10: The initial delay at 0x28 keeps its low 20 bits, which drive `init_dly_o`. The repeat delay at 0x2C keeps all 32 bits, which drive `rpt_dly_o`.
- R11: The wake mask for row r sits at 0x38 + 4*r and keeps COLS bits, one per column. A set bit masks that key from wake. Row r drives `wake_mask_o[r*COLS +: COLS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snap_valid_i | input | 1 | Scanner offers a snapshot this cycle |
| snap_keys_i | input | 64 | Eight byte slots; slot k in bits 8k+7:8k |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Level interrupt on the count threshold |
| scan_en_o | output | 1 | Scan enable to the scanner |
| debounce_o | output | 10 | Debounce count to the scanner |
| init_dly_o | output | 20 | Initial delay to the scanner |
| rpt_dly_o | output | 32 | Repeat delay to the scanner |
| wake_mask_o | output | ROWS*COLS | Per-key wake masks, row-major |

## Verification
The hardest case to reach from the ports is a full queue that is offered one more snapshot. The stimulus first enables capture and then offers DEPTH+1 distinct snapshots back to back without reading any. It then drains the queue one snapshot at a time and compares each against a scoreboard that never accepted the extra snapshot. The status-bit edge is also hard to reach. To get there, the stimulus lets the count cross the threshold, waits for the status bit to set, and then applies a write of 0 and a write of 1 while the count stays above the threshold. A lone read of the high word is also issued to show that it retires nothing.

// File: rtl/ksf_pkg.sv
package ksf_pkg;
    localparam int SLOTS    = 8;
    localparam int SLOT_W   = 8;
    localparam int SNAP_W   = SLOTS * SLOT_W;
    localparam int DEB_W    = 10;
    localparam int THR_W    = 4;
    localparam int INIT_W   = 20;
    localparam int RPT_W    = 32;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_IEN = 3;
    localparam int CTRL_DEB = 4;
    localparam int CTRL_THR = 14;
    localparam int STAT_BIT = 2;
    localparam int CNT_LSB  = 4;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h04;
    localparam logic [7:0] OFS_INIT  = 8'h28;
    localparam logic [7:0] OFS_RPT   = 8'h2C;
    localparam logic [7:0] OFS_ENTLO = 8'h30;
    localparam logic [7:0] OFS_ENTHI = 8'h34;
    localparam logic [7:0] OFS_WAKE0 = 8'h38;

    // Zero every slot whose used flag (bit 7) is clear.
    function automatic logic [SNAP_W-1:0] scrub(input logic [SNAP_W-1:0] s);
        logic [SNAP_W-1:0] r;
        r = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (s[k*SLOT_W + SLOT_W-1]) begin
                r[k*SLOT_W +: SLOT_W] = s[k*SLOT_W +: SLOT_W];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/ksf_fifo.sv
module ksf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = step(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = step(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && st_q.cnt == CNT_W'(DEPTH))
        |=> (st_q.cnt == CNT_W'(DEPTH)) && $stable(st_q.mem));
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.cnt == '0) |=> st_q.cnt == '0);
endmodule

// File: rtl/ksf_regs.sv
module ksf_regs import ksf_pkg::*; #(
    parameter int ROWS   = 16,
    parameter int COLS   = 8,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [31:0]          wdata_i,
    input  logic [CNT_W-1:0]     fifo_cnt_i,
    output logic [31:0]          rdata_o,
    output logic                 en_o,
    output logic                 irq_o,
    output logic [DEB_W-1:0]     deb_o,
    output logic [INIT_W-1:0]    init_o,
    output logic [RPT_W-1:0]     rpt_o,
    output logic [ROWS*COLS-1:0] wake_o
);
    typedef struct packed {
        logic                       en;
        logic                       ien;
        logic [DEB_W-1:0]           deb;
        logic [THR_W-1:0]           thr;
        logic [INIT_W-1:0]          init;
        logic [RPT_W-1:0]           rpt;
        logic [ROWS-1:0][COLS-1:0]  wake;
        logic                       stat;
        logic [THR_W-1:0]           prev_cnt;
    } regs_t;

    regs_t             rg_d, rg_q;
    logic [THR_W-1:0]  cnt4;
    logic              set_evt;
    logic              clr_req;
    logic [ADDR_W-1:0] woff;
    logic              wake_hit;
    logic [ROW_W-1:0]  wake_idx;

    assign cnt4     = THR_W'(fifo_cnt_i);
    assign woff     = addr_i - ADDR_W'(OFS_WAKE0);
    assign wake_hit = (addr_i >= ADDR_W'(OFS_WAKE0)) && (woff[1:0] == 2'b00)
                      && ((woff >> 2) < ADDR_W'(ROWS));
    assign wake_idx = woff[2 +: ROW_W];
    assign set_evt  = (rg_q.thr != '0) && (cnt4 >= rg_q.thr) && (rg_q.prev_cnt < rg_q.thr);
    assign clr_req  = wr_i && (addr_i == ADDR_W'(OFS_STAT)) && wdata_i[STAT_BIT];

    always_comb begin
        rg_d          = rg_q;
        rg_d.prev_cnt = cnt4;
        if (wr_i) begin
            if (addr_i == ADDR_W'(OFS_CTRL)) begin
                rg_d.en  = wdata_i[CTRL_EN];
                rg_d.ien = wdata_i[CTRL_IEN];
                rg_d.deb = wdata_i[CTRL_DEB +: DEB_W];
                rg_d.thr = wdata_i[CTRL_THR +: THR_W];
            end else if (addr_i == ADDR_W'(OFS_INIT)) begin
                rg_d.init = wdata_i[INIT_W-1:0];
            end else if (addr_i == ADDR_W'(OFS_RPT)) begin
                rg_d.rpt = wdata_i[RPT_W-1:0];
            end else if (wake_hit) begin
                rg_d.wake[wake_idx] = wdata_i[COLS-1:0];
            end
        end
        if (clr_req) rg_d.stat = 1'b0;
        if (set_evt) rg_d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_CTRL)) begin
            rdata_o[CTRL_EN]             = rg_q.en;
            rdata_o[CTRL_IEN]            = rg_q.ien;
            rdata_o[CTRL_DEB +: DEB_W]   = rg_q.deb;
            rdata_o[CTRL_THR +: THR_W]   = rg_q.thr;
        end else if (addr_i == ADDR_W'(OFS_STAT)) begin
            rdata_o[STAT_BIT]            = rg_q.stat;
            rdata_o[CNT_LSB +: THR_W]    = cnt4;
        end else if (addr_i == ADDR_W'(OFS_INIT)) begin
            rdata_o[INIT_W-1:0]          = rg_q.init;
        end else if (addr_i == ADDR_W'(OFS_RPT)) begin
            rdata_o[RPT_W-1:0]           = rg_q.rpt;
        end else if (wake_hit) begin
            rdata_o[COLS-1:0]            = rg_q.wake[wake_idx];
        end
    end

    assign en_o   = rg_q.en;
    assign deb_o  = rg_q.deb;
    assign init_o = rg_q.init;
    assign rpt_o  = rg_q.rpt;
    assign irq_o  = rg_q.ien && (rg_q.thr != '0) && (cnt4 >= rg_q.thr);

    for (genvar r = 0; r < ROWS; r++) begin : g_wake
        assign wake_o[r*COLS +: COLS] = rg_q.wake[r];
    end

    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_evt) |=> !rg_q.stat);
    p_stat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.stat && !clr_req) |=> rg_q.stat);
endmodule

// File: rtl/keyscan_fifo_regs.sv
module keyscan_fifo_regs import ksf_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int ROWS   = 16,
    parameter int COLS   = 8,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 snap_valid_i,
    input  logic [SNAP_W-1:0]    snap_keys_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic [31:0]          bus_rdata_o,
    output logic                 irq_o,
    output logic                 scan_en_o,
    output logic [DEB_W-1:0]     debounce_o,
    output logic [INIT_W-1:0]    init_dly_o,
    output logic [RPT_W-1:0]     rpt_dly_o,
    output logic [ROWS*COLS-1:0] wake_mask_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic lo_seen;
    } seq_t;

    seq_t              sq_d, sq_q;
    logic              rd_lo, rd_hi, push, pop;
    logic [SNAP_W-1:0] head, shown;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [31:0]       reg_rdata;

    assign rd_lo = bus_rd_i && (bus_addr_i == ADDR_W'(OFS_ENTLO));
    assign rd_hi = bus_rd_i && (bus_addr_i == ADDR_W'(OFS_ENTHI));
    assign push  = snap_valid_i && scan_en_o;
    assign pop   = rd_hi && sq_q.lo_seen;

    always_comb begin
        sq_d = sq_q;
        if (rd_lo)      sq_d.lo_seen = 1'b1;
        else if (rd_hi) sq_d.lo_seen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    ksf_fifo #(.DEPTH(DEPTH), .W(SNAP_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (snap_keys_i),
        .pop_i   (pop),
        .head_o  (head),
        .count_o (fifo_cnt)
    );

    ksf_regs #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .fifo_cnt_i (fifo_cnt),
        .rdata_o    (reg_rdata),
        .en_o       (scan_en_o),
        .irq_o      (irq_o),
        .deb_o      (debounce_o),
        .init_o     (init_dly_o),
        .rpt_o      (rpt_dly_o),
        .wake_o     (wake_mask_o)
    );

    assign shown = (fifo_cnt == '0) ? '0 : scrub(head);

    always_comb begin
        if (bus_addr_i == ADDR_W'(OFS_ENTLO))      bus_rdata_o = shown[31:0];
        else if (bus_addr_i == ADDR_W'(OFS_ENTHI)) bus_rdata_o = shown[63:32];
        else                                       bus_rdata_o = reg_rdata;
    end

    p_irq_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (fifo_cnt != '0));
    p_lone_hi_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi && !sq_q.lo_seen && !push) |=> fifo_cnt == $past(fifo_cnt));
    p_no_capture_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_en_o && !bus_rd_i) |=> fifo_cnt == $past(fifo_cnt));
endmodule

// File: tb/keyscan_fifo_regs_tb_top.sv
module keyscan_fifo_regs_tb_top;
    localparam int DEPTH = 8;
    localparam int ROWS  = 16;
    localparam int COLS  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snap_valid = 1'b0;
    logic [63:0] snap_keys = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        scan_en;
    logic [9:0]  debounce;
    logic [19:0] init_dly;
    logic [31:0] rpt_dly;
    logic [ROWS*COLS-1:0] wake_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit en_m = 1'b0;
    logic [63:0] sb_q[$];

    always #5 clk = ~clk;

    keyscan_fifo_regs #(.DEPTH(DEPTH), .ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .snap_valid_i (snap_valid),
        .snap_keys_i  (snap_keys),
        .bus_wr_i     (bus_wr),
        .bus_rd_i     (bus_rd),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .irq_o        (irq),
        .scan_en_o    (scan_en),
        .debounce_o   (debounce),
        .init_dly_o   (init_dly),
        .rpt_dly_o    (rpt_dly),
        .wake_mask_o  (wake_mask)
    );

    function automatic logic [63:0] expect_snap(input logic [63:0] s);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++)
            if (s[8*k+7]) r[8*k +: 8] = s[8*k +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Driver: offers a snapshot and records the expected item when accepted.
    task automatic push_snap(input logic [63:0] s);
        @(negedge clk);
        snap_valid = 1'b1; snap_keys = s;
        @(posedge clk); #1;
        snap_valid = 1'b0;
        if (en_m && sb_q.size() < DEPTH) sb_q.push_back(expect_snap(s));
    endtask

    // Monitor: retires one snapshot and compares with the scoreboard head.
    task automatic pop_check(input string tag);
        logic [31:0] lo, hi;
        logic [63:0] exp;
        bus_read(8'h30, lo);
        bus_read(8'h34, hi);
        exp = (sb_q.size() > 0) ? sb_q.pop_front() : 64'h0;
        chk(tag, {hi, lo}, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        bus_read(8'h04, d); chk("R1 status", d, 0);
        bus_read(8'h00, d); chk("R1 ctrl", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wake", wake_mask, 0);
        chk("R1 outputs", {scan_en, debounce, init_dly, rpt_dly}, 0);
        pop_check("R1 entries");

        // R3 capture disabled
        push_snap(64'h8181_8181_8181_8181);
        bus_read(8'h04, d); chk("R3 no capture when off", d, 0);

        // R2 control fields
        bus_write(8'h00, 32'h8000_0000 | (32'd2 << 14) | (32'h2AB << 4) | 32'h9);
        en_m = 1'b1;
        bus_read(8'h00, d); chk("R2 ctrl readback", d, (32'd2 << 14) | (32'h2AB << 4) | 32'h9);
        chk("R2 scan_en", scan_en, 1);
        chk("R2 debounce", debounce, 10'h2AB);

        // R8 threshold 2
        push_snap(64'h0011_C3FF_7F80_9A85);
        chk("R8 irq below threshold", irq, 0);
        bus_read(8'h04, d); chk("R3 count one", d, 32'h10);
        push_snap(64'hF8F1_0102_0304_8807);
        chk("R8 irq at threshold", irq, 1);
        repeat (2) @(posedge clk);
        bus_read(8'h04, d); chk("R9 status set", d, 32'h24);
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, d); chk("R9 write zero keeps", d, 32'h24);
        bus_write(8'h04, 32'h4);
        bus_read(8'h04, d); chk("R9 write one clears", d, 32'h20);
        chk("R8 irq level holds", irq, 1);

        // R5 lone high read
        bus_read(8'h34, d);
        bus_read(8'h04, d); chk("R5 lone hi keeps count", d[7:4], 2);
        pop_check("R4 R5 first snapshot");
        chk("R8 irq drops", irq, 0);
        pop_check("R5 second snapshot");

        // R7 empty
        pop_check("R7 empty reads zero");
        bus_read(8'h04, d); chk("R7 count stays zero", d[7:4], 0);

        // R6 full
        for (int i = 0; i < DEPTH + 1; i++)
            push_snap({8'h80 | 8'(i), 8'h90, 8'h00, 8'hA0 | 8'(i), 8'h7F, 8'h88, 8'h01, 8'hFF - 8'(i)});
        bus_read(8'h04, d); chk("R6 count full", d[7:4], DEPTH);
        for (int i = 0; i < DEPTH; i++) pop_check("R6 drain order");
        bus_read(8'h04, d); chk("R6 drained", d[7:4], 0);

        // R10 delays
        bus_write(8'h28, 32'hFFFF_FFFF);
        bus_read(8'h28, d); chk("R10 init readback", d, 32'hF_FFFF);
        chk("R10 init out", init_dly, 20'hF_FFFF);
        bus_write(8'h2C, 32'hDEAD_1234);
        bus_read(8'h2C, d); chk("R10 rpt readback", d, 32'hDEAD_1234);
        chk("R10 rpt out", rpt_dly, 32'hDEAD_1234);

        // R11 wake masks
        bus_write(8'h38, 32'hA5);
        bus_write(8'h74, 32'h3C);
        bus_write(8'h44, 32'h1FF);
        bus_read(8'h38, d); chk("R11 row0", d, 32'hA5);
        bus_read(8'h74, d); chk("R11 row15", d, 32'h3C);
        bus_read(8'h44, d); chk("R11 row3 width", d, 32'hFF);
        chk("R11 out row0", wake_mask[7:0], 8'hA5);
        chk("R11 out row3", wake_mask[31:24], 8'hFF);
        chk("R11 out row15", wake_mask[127:120], 8'h3C);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule